// File: doc/BRIEF.md
# Transfer queue and completion tracker

This block keeps the books for one transfer engine. Callers first reserve a slot in a small ring, then submit a job into that slot. Each submit receives a 32-bit sequence handle. Whenever the engine is idle and jobs are waiting, the tracker launches the oldest one. It then watches the engine for completion and runs a per-job timeout. When the timeout expires, the tracker issues an abort, and the job counts as finished once the engine drops its enable.

Completed slots do not go straight back to the pool. A service pointer trails the launch pointer and returns one slot per cycle. Callers can ask at any time whether a handle is still pending. The test uses free-running handle counters with a wraparound window, so the answer stays correct after the 32-bit counters roll over. The engine itself is outside this block and is seen only through start, abort, done-clear and off strobes, a done flag and an enable status.

Top module: `xfer_ring_tracker`

## Requirements
- R1: After reset, both handle counters are 0 and `handle_o` reads 0. No job is active, `eng_off_o` is high and `busy_o` is low. Reset leaves SLOTS-1 slots free, so with SLOTS=4 exactly three claims are granted.
- R2: `grant_o` is high in the cycle of `claim_i` exactly when at least one slot is free, and a granted claim takes one slot. A `release_i` pulse hands back one claimed slot. `busy_o` is high whenever no slot is free.
- R3: `handle_o` shows the most recently issued handle, one cycle after each submit, and each submit raises it by one. `slot_o` shows the slot index that the next submit fills; it advances by one on each submit and wraps from SLOTS-1 to 0.
- R4: In any cycle where the engine is idle (or just completed) and jobs are outstanding, `eng_start_o` pulses and `eng_slot_o` gives the oldest job's slot. A submit is first launchable in the cycle after it. When the engine is idle and nothing is outstanding, `eng_off_o` is high.
- R5: While a job is active, `eng_done_i` high makes completion happen in that same cycle. `cmpl_valid_o` and `eng_clr_done_o` pulse, `cmpl_slot_o` names the slot and `cmpl_aborted_o` is 0. If another job is waiting, it is launched in that same cycle.
- R6: If an active job has not completed, `eng_abort_o` pulses TIMEOUT+1 cycles after its start. The deadline then restarts, so without completion the abort repeats every TIMEOUT+1 cycles.
- R7: After an abort, the job completes in the first cycle in which `eng_en_i` is low, with `cmpl_aborted_o` = 1.
- R8: `qry_pending_o` is 1 exactly when both of these hold, modulo 2^32: (done_count − handle) > 2^23, and (issued_count − handle) ≤ 2^23.
- R9: Each slot passed by completion is returned to the free pool, one per cycle, starting the cycle after the completion. Claims can then be granted again.
- R10: `eng_done_i` has no effect while no job is active: no completion is reported and the done counter does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| timeout_i | input | TMO_W | Timeout length in cycles |
| claim_i | input | 1 | Reserve a slot |
| release_i | input | 1 | Hand back a reserved slot unused |
| submit_i | input | 1 | Queue a job into a reserved slot |
| grant_o | output | 1 | Claim accepted this cycle |
| busy_o | output | 1 | No slot free |
| slot_o | output | PW | Slot that the next submit fills |
| handle_o | output | 32 | Last issued handle |
| qry_handle_i | input | 32 | Handle to query |
| qry_pending_o | output | 1 | Queried handle still pending |
| eng_done_i | input | 1 | Engine done flag |
| eng_en_i | input | 1 | Engine enable status |
| eng_start_o | output | 1 | Launch strobe |
| eng_slot_o | output | PW | Slot being launched |
| eng_abort_o | output | 1 | Abort strobe |
| eng_clr_done_o | output | 1 | Clear done flag strobe |
| eng_off_o | output | 1 | Engine should be off |
| cmpl_valid_o | output | 1 | Job completed this cycle |
| cmpl_slot_o | output | PW | Slot of the completed job |
| cmpl_aborted_o | output | 1 | Completed job had been aborted |

## Verification
Completion, clear-done, launch, abort, grant and the query answer are all decided in the same cycle as the inputs that cause them. The handle, the next-slot index and the busy flag change one edge later. A returned slot becomes claimable two edges after the completion cycle. The bench drives inputs just after the falling edge and lets them settle briefly. It then compares every output against a behavioural model that holds the state as of the previous rising edge, and only after that does it advance the model. Every comparison therefore lands in the cycle its result is due.

// File: rtl/xrt_pkg.sv
package xrt_pkg;
  localparam int unsigned HANDLE_W = 32;
  typedef logic [HANDLE_W-1:0] handle_t;
  localparam handle_t PEND_WINDOW = handle_t'(1) << 23;
endpackage

// File: rtl/xrt_handle_win.sv
module xrt_handle_win
  import xrt_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    submit_i,
  input  logic    cmpl_i,
  input  handle_t qry_handle_i,
  output handle_t handle_o,
  output logic    pending_o
);
  handle_t issued_q, done_q;
  handle_t done_gap, issued_gap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issued_q <= '0;
      done_q   <= '0;
    end else begin
      if (submit_i) issued_q <= issued_q + 1'b1;
      if (cmpl_i)   done_q   <= done_q + 1'b1;
    end
  end

  // modular distances give the wraparound window
  assign done_gap   = done_q - qry_handle_i;
  assign issued_gap = issued_q - qry_handle_i;
  assign pending_o  = (done_gap > PEND_WINDOW) && (issued_gap <= PEND_WINDOW);
  assign handle_o   = issued_q;

  p_handle_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    submit_i |=> handle_o == $past(handle_o) + 1'b1);
  p_done_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_i |=> done_q == $past(done_q) + 1'b1);
  p_lag_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issued_q - done_q) <= handle_t'(SLOTS - 1));
endmodule

// File: rtl/xrt_slot_ring.sv
module xrt_slot_ring #(
  parameter int unsigned SLOTS = 4,
  localparam int unsigned PW = $clog2(SLOTS),
  localparam int unsigned CW = $clog2(SLOTS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          claim_i,
  input  logic          release_i,
  input  logic          submit_i,
  input  logic [PW-1:0] cur_ptr_i,
  output logic          grant_o,
  output logic          busy_o,
  output logic [PW-1:0] head_o
);
  localparam bit POW2 = (SLOTS & (SLOTS - 1)) == 0;

  logic [CW-1:0] free_q, free_d;
  logic [PW-1:0] head_q, svc_q, head_inc, svc_inc;
  logic          svc_step;

  generate
    if (POW2) begin : g_pow2
      assign head_inc = head_q + 1'b1;
      assign svc_inc  = svc_q + 1'b1;
    end else begin : g_cmp
      assign head_inc = (head_q == PW'(SLOTS - 1)) ? '0 : head_q + 1'b1;
      assign svc_inc  = (svc_q == PW'(SLOTS - 1)) ? '0 : svc_q + 1'b1;
    end
  endgenerate

  assign grant_o  = claim_i && (free_q != '0);
  assign busy_o   = (free_q == '0);
  assign svc_step = (svc_q != cur_ptr_i);
  assign free_d   = free_q - CW'(grant_o) + CW'(release_i) + CW'(svc_step);
  assign head_o   = head_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= CW'(SLOTS - 1);
      head_q <= '0;
      svc_q  <= '0;
    end else begin
      free_q <= free_d;
      if (submit_i) head_q <= head_inc;
      if (svc_step) svc_q  <= svc_inc;
    end
  end

  p_free_cap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_q <= CW'(SLOTS - 1));
  p_busy_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !release_i && !svc_step |=> busy_o);
  p_svc_return_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_step && !grant_o && !release_i |=> free_q == $past(free_q) + 1'b1);
endmodule

// File: rtl/xrt_engine_seq.sv
module xrt_engine_seq #(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned TMO_W = 16,
  localparam int unsigned PW = $clog2(SLOTS),
  localparam int unsigned CW = $clog2(SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             submit_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic             eng_done_i,
  input  logic             eng_en_i,
  output logic             eng_start_o,
  output logic [PW-1:0]    eng_slot_o,
  output logic             eng_abort_o,
  output logic             eng_clr_done_o,
  output logic             eng_off_o,
  output logic             cmpl_valid_o,
  output logic [PW-1:0]    cmpl_slot_o,
  output logic             cmpl_aborted_o,
  output logic [PW-1:0]    cur_ptr_o
);
  logic [PW-1:0]    cur_q, cur_nx;
  logic [CW-1:0]    outs_q;
  logic [TMO_W-1:0] tmr_q;
  logic             active_q, aborting_q;
  logic             done_x, expire, idle, launch;

  assign done_x = (active_q && eng_done_i) || (aborting_q && !eng_en_i);
  assign expire = !done_x && active_q && (tmr_q == '0);
  assign idle   = !active_q || done_x;
  assign launch = idle && (outs_q != '0);
  assign cur_nx = !done_x ? cur_q :
                  (cur_q == PW'(SLOTS - 1)) ? '0 : cur_q + 1'b1;

  assign eng_start_o    = launch;
  assign eng_slot_o     = cur_nx;
  assign eng_abort_o    = expire;
  assign eng_clr_done_o = done_x;
  assign eng_off_o      = idle && (outs_q == '0);
  assign cmpl_valid_o   = done_x;
  assign cmpl_slot_o    = cur_q;
  assign cmpl_aborted_o = done_x && aborting_q;
  assign cur_ptr_o      = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q      <= '0;
      outs_q     <= '0;
      tmr_q      <= '0;
      active_q   <= 1'b0;
      aborting_q <= 1'b0;
    end else begin
      cur_q  <= cur_nx;
      outs_q <= outs_q + CW'(submit_i) - CW'(launch);
      if (launch)      active_q <= 1'b1;
      else if (done_x) active_q <= 1'b0;
      if (done_x)      aborting_q <= 1'b0;
      else if (expire) aborting_q <= 1'b1;
      if (launch || expire)        tmr_q <= timeout_i;
      else if (active_q && !done_x) tmr_q <= tmr_q - 1'b1;
    end
  end

  p_start_arms_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> active_q && tmr_q == $past(timeout_i));
  p_abort_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_abort_o |-> active_q && !eng_start_o);
  p_abort_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_abort_o |=> aborting_q);
  p_cmpl_frees_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_o && !eng_start_o |=> !active_q);
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !cmpl_valid_o && !eng_abort_o);
endmodule

// File: rtl/xfer_ring_tracker.sv
module xfer_ring_tracker
  import xrt_pkg::*;
#(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned TMO_W = 16,
  localparam int unsigned PW = $clog2(SLOTS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TMO_W-1:0]    timeout_i,
  input  logic                claim_i,
  input  logic                release_i,
  input  logic                submit_i,
  output logic                grant_o,
  output logic                busy_o,
  output logic [PW-1:0]       slot_o,
  output logic [HANDLE_W-1:0] handle_o,
  input  logic [HANDLE_W-1:0] qry_handle_i,
  output logic                qry_pending_o,
  input  logic                eng_done_i,
  input  logic                eng_en_i,
  output logic                eng_start_o,
  output logic [PW-1:0]       eng_slot_o,
  output logic                eng_abort_o,
  output logic                eng_clr_done_o,
  output logic                eng_off_o,
  output logic                cmpl_valid_o,
  output logic [PW-1:0]       cmpl_slot_o,
  output logic                cmpl_aborted_o
);
  logic [PW-1:0] cur_ptr;

  xrt_slot_ring #(.SLOTS(SLOTS)) u_ring (
    .clk_i, .rst_ni, .claim_i, .release_i, .submit_i,
    .cur_ptr_i(cur_ptr), .grant_o, .busy_o, .head_o(slot_o)
  );

  xrt_engine_seq #(.SLOTS(SLOTS), .TMO_W(TMO_W)) u_seq (
    .clk_i, .rst_ni, .submit_i, .timeout_i, .eng_done_i, .eng_en_i,
    .eng_start_o, .eng_slot_o, .eng_abort_o, .eng_clr_done_o, .eng_off_o,
    .cmpl_valid_o, .cmpl_slot_o, .cmpl_aborted_o, .cur_ptr_o(cur_ptr)
  );

  xrt_handle_win #(.SLOTS(SLOTS)) u_hwin (
    .clk_i, .rst_ni, .submit_i, .cmpl_i(cmpl_valid_o),
    .qry_handle_i, .handle_o, .pending_o(qry_pending_o)
  );

  p_launch_slot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_o && eng_start_o |-> eng_slot_o != cmpl_slot_o);
endmodule

// File: tb/xfer_ring_tracker_test.sv
module xfer_ring_tracker_test;
  localparam int S = 4;
  localparam int T = 6;
  localparam int PW = $clog2(S);

  logic clk = 1'b0, rst_n = 1'b0;
  logic cl = 0, rl = 0, sb = 0, dn = 0, en = 1;
  logic [31:0] qh = '0;
  logic grant, busy, start, abrt, clr, off, cmpl, cabt, pend;
  logic [PW-1:0] slot, eslot, cslot;
  logic [31:0] hnd;

  always #4 clk = ~clk;

  xfer_ring_tracker #(.SLOTS(S), .TMO_W(16)) uut (
    .clk_i(clk), .rst_ni(rst_n), .timeout_i(16'(T)),
    .claim_i(cl), .release_i(rl), .submit_i(sb),
    .grant_o(grant), .busy_o(busy), .slot_o(slot), .handle_o(hnd),
    .qry_handle_i(qh), .qry_pending_o(pend),
    .eng_done_i(dn), .eng_en_i(en),
    .eng_start_o(start), .eng_slot_o(eslot), .eng_abort_o(abrt),
    .eng_clr_done_o(clr), .eng_off_o(off),
    .cmpl_valid_o(cmpl), .cmpl_slot_o(cslot), .cmpl_aborted_o(cabt)
  );

  int vec = 0, bad = 0, held = 0;
  int m_free = S - 1, m_outs = 0, m_cur = 0, m_svc = 0, m_head = 0;
  int m_act = 0, m_abt = 0, m_tmr = 0;
  logic [31:0] m_ch = '0, m_dh = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp(input string req, input longint act, input longint exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic step(input bit c, input bit r, input bit s, input bit d, input bit e);
    bit g, dx, ex, idl, ln, pe;
    int ncur;
    @(negedge clk);
    cl = c; rl = r; sb = s; dn = d; en = e;
    #1;
    g   = c && (m_free > 0);
    dx  = (m_act && d) || (m_abt && !e);
    ex  = !dx && m_act && (m_tmr == 0);
    idl = !m_act || dx;
    ln  = idl && (m_outs > 0);
    ncur = dx ? (m_cur + 1) % S : m_cur;
    pe  = ((m_dh - qh) > 32'h0080_0000) && ((m_ch - qh) <= 32'h0080_0000);
    cmp("R2 grant", grant, g);
    cmp("R2 busy", busy, m_free == 0);
    cmp("R3 slot", slot, m_head);
    cmp("R3 handle", hnd, m_ch);
    cmp("R4 start", start, ln);
    if (ln) cmp("R4 start slot", eslot, ncur);
    cmp("R4 off", off, idl && (m_outs == 0));
    cmp("R6 abort", abrt, ex);
    cmp("R5 clear", clr, dx);
    cmp("R5 complete", cmpl, dx);
    if (dx) cmp("R5 complete slot", cslot, m_cur);
    cmp("R7 aborted", cabt, dx && m_abt);
    cmp("R8 pending", pend, pe);
    // advance model
    m_free = m_free - int'(g) + int'(r) + int'(m_svc != m_cur);
    if (m_svc != m_cur) m_svc = (m_svc + 1) % S;
    if (s) begin m_head = (m_head + 1) % S; m_ch = m_ch + 1; end
    if (dx) m_dh = m_dh + 1;
    m_outs = m_outs + int'(s) - int'(ln);
    if (ln) m_tmr = T; else if (ex) m_tmr = T; else if (m_act && !dx) m_tmr = m_tmr - 1;
    if (ln) m_act = 1; else if (dx) m_act = 0;
    if (dx) m_abt = 0; else if (ex) m_abt = 1;
    m_cur = ncur;
    if (g) held++;
    if (r || s) held--;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    int gc;
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 1);
    chk(off && !busy && hnd == 0, "R1 reset state", {off, busy}, 2'b10);
    // R2: three of four claims granted
    gc = 0;
    for (int i = 0; i < 4; i++) begin step(1, 0, 0, 0, 1); gc += int'(grant); end
    cmp("R1 initial free slots", gc, S - 1);
    step(1, 0, 0, 0, 1);
    chk(!grant && busy, "R2 refuse when full", grant, 0);
    step(0, 1, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    chk(grant, "R2 claim after release", grant, 1);
    // R4: launch next cycle after submit
    step(0, 0, 1, 0, 1);
    chk(!start, "R4 no launch in submit cycle", start, 0);
    step(0, 0, 0, 0, 1);
    chk(start && eslot == 0, "R4 launch slot", eslot, 0);
    qh = 32'd1; step(0, 0, 0, 0, 1);
    chk(pend, "R8 issued handle pending", pend, 1);
    qh = 32'd2; step(0, 0, 0, 0, 1);
    chk(!pend, "R8 future handle not pending", pend, 0);
    qh = 32'd1; step(0, 0, 0, 1, 1);
    chk(cmpl && !cabt && clr, "R5 normal completion", cmpl, 1);
    step(0, 0, 0, 0, 1);
    chk(!pend, "R8 done handle not pending", pend, 0);
    // R5: relaunch in the completion cycle
    step(0, 0, 1, 0, 1);
    step(0, 0, 1, 0, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 1);
    chk(cmpl && start && eslot == 2, "R5 back-to-back launch", eslot, 2);
    // R6: timeout abort after T+1 cycles, repeating
    gc = 0;
    for (int i = 1; i <= T + 1; i++) begin
      step(0, 0, 0, 0, 1);
      if (abrt) gc += (i == T + 1) ? 1 : 100;
    end
    cmp("R6 abort at deadline", gc, 1);
    gc = 0;
    for (int i = 1; i <= T + 1; i++) begin
      step(0, 0, 0, 0, 1);
      if (abrt) gc += (i == T + 1) ? 1 : 100;
    end
    cmp("R6 repeated abort", gc, 1);
    step(0, 0, 0, 0, 0);
    chk(cmpl && cabt, "R7 aborted completion", cabt, 1);
    idle(2);
    // R10: stray done flag while idle
    step(0, 0, 0, 1, 1);
    chk(!cmpl, "R10 done ignored when idle", cmpl, 0);
    // R9: slots come back
    idle(2);
    gc = 0;
    for (int i = 0; i < 4; i++) begin step(1, 0, 0, 0, 1); gc += int'(grant); end
    cmp("R9 slots returned", gc, S - 1);
    // R3: head wraps
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 1, 0, 1);
      idle(1);
      step(0, 0, 0, 1, 1);
    end
    idle(1);
    chk(hnd == 32'd6 && slot == 2, "R3 handle and slot wrap", slot, 2);
    // mixed traffic
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      bit c, s, r, d, e;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      c = lf[0];
      s = (held > 0) && lf[1];
      r = (held > 0) && !s && lf[2] && lf[3];
      d = lf[4] & lf[5];
      e = !(lf[6] & lf[7] & lf[8]);
      qh = m_ch - 32'(lf[11:9] % 6);
      step(c, r, s, d, e);
    end
    qh = 32'hFFFF_FFF0; step(0, 0, 0, 0, 1);
    chk(!pend, "R8 wrapped-behind handle", pend, 0);
    finish_up();
  end
endmodule